// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block takes received Ethernet frames one byte per cycle on a valid/ready stream and stores each one through a descriptor ring in system memory. For every frame it reads the descriptor at the current ring pointer. If the descriptor is owned by the hardware, the frame bytes are written as 32-bit little-endian words to the descriptor's buffer address. The block then writes a completion word back to the descriptor and steps the ring pointer.

Each frame that is stored is sorted by its destination address into unicast, multicast or broadcast, and 64-bit statistics counters are updated. Two one-cycle event pulses tell a neighbouring status register block what happened: "receive done" sets the receive-interrupt and normal-summary bits, and "no descriptor" sets the buffer-unavailable and abnormal-summary bits.

The first `MIN_LEN` (12) bytes of a frame are held in registers until the frame is known not to be a runt. Memory is therefore never touched for a frame that is too short. The descriptor layout is three words:

- Offset 0: bit 31 is the ownership bit.
- Offset 4: bit 15 marks the end of the ring.
- Offset 8: the word-aligned buffer address.

Top module: `rxd_writeback`

## Requirements
- R1: A frame starts only while `rx_enable` is 1. While the block is idle and `rx_enable` is 0, `in_ready` stays 0 and no memory access happens. Once a frame has started, it completes even if `rx_enable` falls.
- R2: A stored frame's bytes land in consecutive memory bytes starting at the buffer address, little-endian within each word. The last, partial word is written with byte strobes for its valid bytes only, so bytes past the frame end keep their old value.
- R3: A frame shorter than 12 bytes causes no memory read or write. It still gives one `evt_rx_done` pulse, and it leaves the counters and `cur_desc_ptr` unchanged.
- R4: If bit 31 of descriptor word 0 is 0, the rest of the frame is consumed and discarded, with no memory write. The block gives one `evt_no_desc` pulse and no `evt_rx_done`, and leaves the counters and the pointer unchanged.
- R5: After the last data word, the block writes ((length + 4) mod 65536) << 16 | 0x300 to descriptor word 0. This write-back is the last write for the frame.
- R6: After a write-back, `cur_desc_ptr` reloads from `rx_base` if bit 15 of descriptor word 1 is set, and otherwise advances by 32. A `base_load` pulse while idle copies `rx_base` into `cur_desc_ptr`.
- R7: A frame is unicast when bit 0 of its first byte is 0, broadcast when its first six bytes are all 0xFF, and multicast otherwise. For each stored frame, `cnt_frames` rises by 1 and `cnt_bytes` by length + 4. `cnt_mcast` or `cnt_bcast` rises by 1 according to the class. All counters are 0 after reset.
- R8: Each stored frame and each runt gives exactly one single-cycle `evt_rx_done`. `evt_rx_done` and `evt_no_desc` are never high together.
- R9: `rd_valid` and `wr_valid`, once high, hold their address, data and strobes steady until the matching ready is seen. Write back-pressure only delays the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_enable | input | 1 | Receive start enable |
| rx_base | input | AW | Ring base address |
| base_load | input | 1 | Copy ring base into the current pointer |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | AW | Read address |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 32 | Read data |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Byte strobes |
| wr_ready | input | 1 | Write accepted |
| evt_rx_done | output | 1 | Receive-done pulse |
| evt_no_desc | output | 1 | No-descriptor pulse |
| cur_desc_ptr | output | AW | Current descriptor address |
| cnt_bytes | output | CNT_W | Received byte count |
| cnt_frames | output | CNT_W | Stored frame count |
| cnt_mcast | output | CNT_W | Multicast frame count |
| cnt_bcast | output | CNT_W | Broadcast frame count |

## Verification
The assertions assume the following about the environment:

- Memory returns exactly one `rd_rvalid` for each accepted read request, and returns it after that request.
- `base_load` is pulsed only while no frame is in flight.
- Descriptor and buffer addresses are word aligned.

The bench's memory model answers every read one cycle after accepting it. It loads the base only between frames and uses only aligned addresses. It toggles `wr_ready` during one frame so that the hold rules are exercised under stall.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {CL_UNI, CL_MULTI, CL_BCAST} frame_cls_e;

  typedef enum logic [2:0] {
    S_COLLECT, S_DRQ, S_DRS, S_FLUSH, S_STREAM, S_DRAIN, S_WB
  } rxd_state_e;

  // completion word: length with CRC allowance in the top half, first/last flags
  function automatic logic [31:0] wb_word(input logic [15:0] len);
    logic [15:0] t;
    t = len + 16'd4;
    return {t, 16'h0300};
  endfunction

  // destination address, first byte in bits 7:0
  function automatic frame_cls_e classify(input logic [47:0] da);
    if (!da[0])   return CL_UNI;
    else if (&da) return CL_BCAST;
    else          return CL_MULTI;
  endfunction

  function automatic logic [3:0] strb_of(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/rxd_packer.sv
module rxd_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [7:0]  din,
  input  logic        dlast,
  input  logic        pop,
  output logic [31:0] word,
  output logic [3:0]  strb,
  output logic        done,
  output logic        last
);
  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
      done <= 1'b0;
      last <= 1'b0;
    end else if (pop) begin
      cnt  <= '0;
      done <= 1'b0;
      last <= 1'b0;
    end else if (take) begin
      word[cnt[1:0]*8 +: 8] <= din;
      cnt  <= cnt + 3'd1;
      done <= (cnt == 3'd3) || dlast;
      last <= dlast;
    end
  end

  assign strb = rxd_pkg::strb_of(cnt);
endmodule

// File: rtl/rxd_stats.sv
module rxd_stats #(
  parameter int CNT_W = 64,
  parameter int LEN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic [LEN_W-1:0]    len,
  input  rxd_pkg::frame_cls_e cls,
  output logic [CNT_W-1:0]    cnt_bytes,
  output logic [CNT_W-1:0]    cnt_frames,
  output logic [CNT_W-1:0]    cnt_mcast,
  output logic [CNT_W-1:0]    cnt_bcast
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_bytes  <= '0;
      cnt_frames <= '0;
      cnt_mcast  <= '0;
      cnt_bcast  <= '0;
    end else if (upd) begin
      cnt_bytes  <= cnt_bytes + CNT_W'(len) + CNT_W'(4);
      cnt_frames <= cnt_frames + CNT_W'(1);
      if (cls == rxd_pkg::CL_MULTI) cnt_mcast <= cnt_mcast + CNT_W'(1);
      if (cls == rxd_pkg::CL_BCAST) cnt_bcast <= cnt_bcast + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rxd_writeback.sv
module rxd_writeback #(
  parameter int AW         = 32,
  parameter int CNT_W      = 64,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 12,
  parameter int DESC_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic [AW-1:0]    rx_base,
  input  logic             base_load,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             rd_valid,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ready,
  input  logic             rd_rvalid,
  input  logic [31:0]      rd_rdata,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [31:0]      wr_data,
  output logic [3:0]       wr_strb,
  input  logic             wr_ready,
  output logic             evt_rx_done,
  output logic             evt_no_desc,
  output logic [AW-1:0]    cur_desc_ptr,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_mcast,
  output logic [CNT_W-1:0] cnt_bcast
);
  import rxd_pkg::*;

  localparam int HDR_WORDS = MIN_LEN / 4;
  localparam int HW_W      = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;

  rxd_state_e       st;
  logic [31:0]      hdr [HDR_WORDS];
  logic [HW_W-1:0]  hcnt, fidx;
  logic [1:0]       didx;
  logic [LEN_W-1:0] len_cnt;
  logic             ended, ring_end;
  logic [AW-1:0]    buf_addr;

  logic [31:0] pk_word;
  logic [3:0]  pk_strb;
  logic        pk_done, pk_last, pk_take, pk_pop, acc;

  // named internal events, used by the checker
  logic frm_first, wb_fire, runt_fire;

  assign acc       = in_valid && in_ready;
  assign pk_take   = acc && (st == S_COLLECT || st == S_STREAM);
  assign frm_first = (st == S_COLLECT) && (len_cnt == '0);
  assign runt_fire = (st == S_COLLECT) && pk_done && pk_last && (len_cnt < LEN_W'(MIN_LEN));
  assign wb_fire   = (st == S_WB) && wr_ready;
  assign pk_pop    = ((st == S_COLLECT) && pk_done) ||
                     ((st == S_STREAM) && pk_done && wr_ready);

  always_comb begin
    case (st)
      S_COLLECT: in_ready = !pk_done && (len_cnt != '0 || rx_enable);
      S_STREAM:  in_ready = !pk_done;
      S_DRAIN:   in_ready = 1'b1;
      default:   in_ready = 1'b0;
    endcase
  end

  assign rd_valid = (st == S_DRQ);
  assign rd_addr  = cur_desc_ptr + AW'({didx, 2'b00});

  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = buf_addr;
    wr_data  = hdr[fidx];
    wr_strb  = 4'hF;
    case (st)
      S_FLUSH:  wr_valid = 1'b1;
      S_STREAM: begin
        wr_valid = pk_done;
        wr_data  = pk_word;
        wr_strb  = pk_strb;
      end
      S_WB: begin
        wr_valid = 1'b1;
        wr_addr  = cur_desc_ptr;
        wr_data  = wb_word(16'(len_cnt));
      end
      default: ;
    endcase
  end

  rxd_packer u_pack (
    .clk(clk), .rst_n(rst_n), .take(pk_take), .din(in_data), .dlast(in_last),
    .pop(pk_pop), .word(pk_word), .strb(pk_strb), .done(pk_done), .last(pk_last)
  );

  rxd_stats #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .upd(wb_fire), .len(len_cnt),
    .cls(classify({hdr[1][15:0], hdr[0]})),
    .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames),
    .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_COLLECT;
      for (int i = 0; i < HDR_WORDS; i++) hdr[i] <= '0;
      hcnt         <= '0;
      fidx         <= '0;
      didx         <= '0;
      len_cnt      <= '0;
      ended        <= 1'b0;
      ring_end     <= 1'b0;
      buf_addr     <= '0;
      cur_desc_ptr <= '0;
      evt_rx_done  <= 1'b0;
      evt_no_desc  <= 1'b0;
    end else begin
      evt_rx_done <= 1'b0;
      evt_no_desc <= 1'b0;
      if (pk_take) len_cnt <= len_cnt + LEN_W'(1);
      if (base_load) cur_desc_ptr <= rx_base;
      case (st)
        S_COLLECT: if (pk_done) begin
          if (runt_fire) begin
            evt_rx_done <= 1'b1;
            len_cnt     <= '0;
            hcnt        <= '0;
          end else begin
            hdr[hcnt] <= pk_word;
            if (hcnt == HW_W'(HDR_WORDS - 1)) begin
              hcnt  <= '0;
              didx  <= '0;
              ended <= pk_last;
              st    <= S_DRQ;
            end else begin
              hcnt <= hcnt + HW_W'(1);
            end
          end
        end
        S_DRQ: if (rd_ready) st <= S_DRS;
        S_DRS: if (rd_rvalid) begin
          case (didx)
            2'd0: begin
              if (!rd_rdata[31]) begin
                if (ended) begin
                  evt_no_desc <= 1'b1;
                  len_cnt     <= '0;
                  st          <= S_COLLECT;
                end else begin
                  st <= S_DRAIN;
                end
              end else begin
                didx <= 2'd1;
                st   <= S_DRQ;
              end
            end
            2'd1: begin
              ring_end <= rd_rdata[15];
              didx     <= 2'd2;
              st       <= S_DRQ;
            end
            default: begin
              buf_addr <= AW'(rd_rdata);
              fidx     <= '0;
              st       <= S_FLUSH;
            end
          endcase
        end
        S_FLUSH: if (wr_ready) begin
          buf_addr <= buf_addr + AW'(4);
          if (fidx == HW_W'(HDR_WORDS - 1)) st <= ended ? S_WB : S_STREAM;
          else fidx <= fidx + HW_W'(1);
        end
        S_STREAM: if (pk_done && wr_ready) begin
          buf_addr <= buf_addr + AW'(4);
          if (pk_last) st <= S_WB;
        end
        S_DRAIN: if (in_valid && in_last) begin
          evt_no_desc <= 1'b1;
          len_cnt     <= '0;
          st          <= S_COLLECT;
        end
        S_WB: if (wr_ready) begin
          cur_desc_ptr <= ring_end ? rx_base : cur_desc_ptr + AW'(DESC_BYTES);
          evt_rx_done  <= 1'b1;
          len_cnt      <= '0;
          st           <= S_COLLECT;
        end
        default: st <= S_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/rxd_writeback_chk.sv
module rxd_writeback_chk #(
  parameter int AW         = 32,
  parameter int CNT_W      = 64,
  parameter int DESC_BYTES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enable,
  input logic [AW-1:0]    rx_base,
  input logic             base_load,
  input logic             in_valid,
  input logic             in_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [AW-1:0]    rd_addr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [AW-1:0]    wr_addr,
  input logic [31:0]      wr_data,
  input logic [3:0]       wr_strb,
  input logic             evt_rx_done,
  input logic             evt_no_desc,
  input logic [AW-1:0]    cur_desc_ptr,
  input logic [CNT_W-1:0] cnt_frames,
  input logic             frm_first,
  input logic             wb_fire
);
  assert_ena_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_first && in_valid && in_ready) |-> rx_enable);

  assert_evt_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_rx_done && evt_no_desc));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && !base_load) |=>
      (cur_desc_ptr == $past(cur_desc_ptr) + AW'(DESC_BYTES)) ||
      (cur_desc_ptr == $past(rx_base)));

  assert_frames_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> cnt_frames == $past(cnt_frames) + CNT_W'(1));

  assert_nodesc_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_no_desc |-> $stable(cnt_frames));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));
endmodule

bind rxd_writeback rxd_writeback_chk #(.AW(AW), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_base(rx_base),
  .base_load(base_load), .in_valid(in_valid), .in_ready(in_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_strb(wr_strb), .evt_rx_done(evt_rx_done),
  .evt_no_desc(evt_no_desc), .cur_desc_ptr(cur_desc_ptr),
  .cnt_frames(cnt_frames), .frm_first(frm_first), .wb_fire(wb_fire)
);

// File: tb/rxd_writeback_tb.sv
module rxd_writeback_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rx_enable = 1'b0, base_load = 1'b0;
  logic [31:0] rx_base = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        rd_valid, rd_rvalid = 1'b0;
  logic        rd_ready = 1'b1;
  logic [31:0] rd_addr, rd_rdata = '0;
  logic        wr_valid, wr_ready = 1'b1, stall_mode = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_strb;
  logic        evt_rx_done, evt_no_desc;
  logic [31:0] cur_desc_ptr;
  logic [63:0] cnt_bytes, cnt_frames, cnt_mcast, cnt_bcast;

  rxd_writeback u_dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_base(rx_base),
    .base_load(base_load), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .wr_ready(wr_ready),
    .evt_rx_done(evt_rx_done), .evt_no_desc(evt_no_desc),
    .cur_desc_ptr(cur_desc_ptr), .cnt_bytes(cnt_bytes),
    .cnt_frames(cnt_frames), .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast)
  );

  logic [31:0] mem [1024];
  int n_rd = 0, n_wr = 0, n_done = 0, n_nd = 0;
  logic [31:0] last_wr_addr = '0;
  int checks = 0, fails = 0;
  logic [63:0] e_bytes = 0, e_frames = 0, e_mc = 0, e_bc = 0;
  logic [7:0] fb [256];

  always @(posedge clk) begin
    rd_rvalid <= 1'b0;
    if (rd_valid && rd_ready) begin
      rd_rvalid <= 1'b1;
      rd_rdata  <= mem[rd_addr[11:2]];
      n_rd <= n_rd + 1;
    end
    if (wr_valid && wr_ready) begin
      for (int b = 0; b < 4; b++)
        if (wr_strb[b]) mem[wr_addr[11:2]][b*8 +: 8] <= wr_data[b*8 +: 8];
      n_wr <= n_wr + 1;
      last_wr_addr <= wr_addr;
    end
    wr_ready <= stall_mode ? ~wr_ready : 1'b1;
    if (evt_rx_done) n_done <= n_done + 1;
    if (evt_no_desc) n_nd <= n_nd + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdbyte(input logic [31:0] a);
    return mem[a[11:2]][a[1:0]*8 +: 8];
  endfunction

  // kind: 0 unicast, 1 broadcast, 2 multicast
  task automatic fill_frame(input int len, input int kind);
    for (int i = 0; i < len; i++) fb[i] = 8'((i * 13 + 5) & 8'hFF);
    if (kind == 1) for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
    else if (kind == 2) fb[0] = 8'h01;
    else fb[0] = 8'h02;
  endtask

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_evt(input bit nodesc, input int target, input string req);
    for (int i = 0; i < 3000; i++) begin
      if ((nodesc ? n_nd : n_done) >= target) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check(req, nodesc ? n_nd : n_done, target);
  endtask

  task automatic set_desc(input logic [31:0] a, input bit own, input bit rend, input logic [31:0] bufa);
    mem[a[11:2]]     = own ? 32'h8000_0000 : 32'h0;
    mem[a[11:2] + 1] = rend ? 32'h0000_8000 : 32'h0;
    mem[a[11:2] + 2] = bufa;
  endtask

  task automatic t_reset;
    check("R7 reset bytes", cnt_bytes, 0);
    check("R7 reset frames", cnt_frames, 0);
    check("R6 reset ptr", cur_desc_ptr, 0);
    check("R9 reset wr_valid", wr_valid, 0);
    check("R8 reset events", {evt_rx_done, evt_no_desc}, 0);
  endtask

  task automatic t_disabled;
    int bad = 0;
    rx_enable = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h02; in_last = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (in_ready) bad++;
    end
    in_valid = 1'b0;
    check("R1 ready low while disabled", bad, 0);
    check("R1 no memory reads", n_rd, 0);
  endtask

  task automatic t_store(input logic [31:0] d, input logic [31:0] bufa, input int len,
                         input int kind, input bit rend, input bit stall, input string tag);
    int bad = 0;
    int done0 = n_done;
    for (int i = 0; i < (len + 8) / 4 + 1; i++) mem[bufa[11:2] + i] = 32'hA5A5_A5A5;
    set_desc(d, 1'b1, rend, bufa);
    fill_frame(len, kind);
    stall_mode = stall;
    send(len);
    wait_evt(1'b0, done0 + 1, {"R8 done pulse ", tag});
    stall_mode = 1'b0;
    for (int i = 0; i < len; i++) if (rdbyte(bufa + i) !== fb[i]) bad++;
    check({"R2 data ", tag}, bad, 0);
    bad = 0;
    for (int i = len; i < ((len + 3) / 4) * 4 + 4; i++) if (rdbyte(bufa + i) !== 8'hA5) bad++;
    check({"R2 tail untouched ", tag}, bad, 0);
    check({"R5 write-back word ", tag}, mem[d[11:2]], {16'(len + 4), 16'h0300});
    check({"R5 write-back last ", tag}, last_wr_addr, d);
    check({"R6 pointer ", tag}, cur_desc_ptr, rend ? rx_base : d + 32);
    e_frames++; e_bytes += 64'(len + 4);
    if (kind == 1) e_bc++; else if (kind == 2) e_mc++;
    check({"R7 bytes ", tag}, cnt_bytes, e_bytes);
    check({"R7 frames ", tag}, cnt_frames, e_frames);
    check({"R7 mcast ", tag}, cnt_mcast, e_mc);
    check({"R7 bcast ", tag}, cnt_bcast, e_bc);
  endtask

  task automatic t_runt;
    int rd0 = n_rd, wr0 = n_wr, done0 = n_done;
    logic [31:0] p0 = cur_desc_ptr;
    set_desc(p0, 1'b1, 1'b0, 32'h0000_0C00);
    fill_frame(11, 0);
    send(11);
    wait_evt(1'b0, done0 + 1, "R3 runt done pulse");
    check("R3 runt no reads", n_rd, rd0);
    check("R3 runt no writes", n_wr, wr0);
    check("R3 runt ptr", cur_desc_ptr, p0);
    check("R3 runt frames", cnt_frames, e_frames);
    check("R3 runt desc intact", mem[p0[11:2]], 32'h8000_0000);
  endtask

  task automatic t_nodesc;
    int wr0 = n_wr, nd0 = n_nd, done0 = n_done;
    logic [31:0] p0 = cur_desc_ptr;
    set_desc(p0, 1'b0, 1'b0, 32'h0000_0C00);
    fill_frame(30, 2);
    send(30);
    wait_evt(1'b1, nd0 + 1, "R4 no-desc pulse");
    check("R4 no writes", n_wr, wr0);
    check("R4 no done pulse", n_done, done0);
    check("R4 ptr kept", cur_desc_ptr, p0);
    check("R4 frames kept", cnt_frames, e_frames);
    check("R4 mcast kept", cnt_mcast, e_mc);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    rx_base = 32'h100;
    base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    check("R6 base load", cur_desc_ptr, 32'h100);
    rx_enable = 1'b1;
    t_store(32'h100, 32'h800, 20, 0, 1'b0, 1'b0, "unicast");
    t_store(32'h120, 32'h900, 13, 1, 1'b0, 1'b1, "broadcast stalled");
    t_store(32'h140, 32'hA00, 64, 2, 1'b0, 1'b0, "multicast");
    t_runt();
    t_nodesc();
    t_store(32'h160, 32'hB00, 12, 0, 1'b1, 1'b0, "min length ring end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule